// File: doc/BRIEF.md
# Privileged Test-Register Move Decoder

This block decodes the two-byte escape opcodes that move a 32-bit value between a general-purpose register (GPR) and a small file of test registers, numbered 3 to 7. One instruction is presented per cycle with a valid strobe, together with the ModR/M byte, the current privilege level and a protected-mode flag. The block selects the GPR to read from the r/m field, checks whether the access is legal, and one clock later either updates a test register, returns test-register data toward the GPR file, or raises exactly one fault flag.

Registers 3, 4 and 5 serve cache testing (data, address, command), and registers 6 and 7 serve translation-buffer testing (command, data). The block holds their contents. It does not perform the test actions itself. A write to either command register produces a one-cycle strobe, and logic outside the block starts the test from that strobe. Indices 0 to 2 are not implemented. A mod field other than register-direct is rejected instead of being left undefined.

Top module: `trmove_dec`

## Requirements
- R1: After reset, every output is zero and all five test registers hold zero.
- R2: With escape byte 0x0F and code byte 0x26, an accepted instruction copies `gpr_rdata` (the GPR named by r/m, bits 2:0, presented on `gpr_ridx`) into the test register named by the reg field (bits 5:3). `tr_wr_stb` bit (reg-3) is high for exactly the one cycle after the strobe.
- R3: With escape byte 0x0F and code byte 0x24, an accepted instruction drives `gpr_we`=1, `gpr_widx`=r/m and `gpr_wdata`=the named test register's value, for exactly the one cycle after the strobe.
- R4: When `prot_mode`=1 and `cpl`≠0, the instruction raises `fault_gp` and changes no state. When `prot_mode`=0, any `cpl` is accepted.
- R5: A mod field (bits 7:6) other than 2'b11 raises `fault_ud` and changes no state.
- R6: A reg field of 0, 1 or 2 raises `fault_ud` and changes no state.
- R7: The checks have a fixed priority: privilege first, then mod, then index. Exactly one fault flag is raised per rejected instruction. `fault_why` gives the cause: 0 none, 1 privilege, 2 mod, 3 index.
- R8: A write to register 5 pulses `cache_cmd_stb`, and a write to register 6 pulses `tlb_cmd_stb`, each for one cycle. Writes to the other registers pulse neither.
- R9: A cycle with `insn_vld` low, or with an opcode pair other than the two above, leaves all registered outputs at zero and changes no test register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| insn_vld | input | 1 | Instruction present this cycle |
| op_esc | input | 8 | First opcode byte |
| op_code | input | 8 | Second opcode byte |
| modrm | input | 8 | ModR/M byte |
| cpl | input | 2 | Current privilege level |
| prot_mode | input | 1 | Protected mode active |
| gpr_ridx | output | 3 | GPR read select (r/m field) |
| gpr_rdata | input | 32 | Data of the selected GPR |
| gpr_we | output | 1 | GPR write enable |
| gpr_widx | output | 3 | GPR write index |
| gpr_wdata | output | 32 | GPR write data |
| tr_wr_stb | output | 5 | One-hot write strobe, bit 0 is register 3 |
| cache_cmd_stb | output | 1 | Cache test command written |
| tlb_cmd_stb | output | 1 | Translation-buffer test command written |
| fault_gp | output | 1 | General protection fault |
| fault_ud | output | 1 | Invalid opcode fault |
| fault_why | output | 2 | Fault cause code |

## Verification
A corrupted test-register value does not appear at the ports when it is written. It appears only at the next 0x24 read of that register, as a wrong `gpr_wdata` one cycle after that read's strobe. The bench therefore follows random writes with reads from random registers, and it tracks every register's expected value. A fault-priority error or a write that leaks through shows up one cycle after the offending strobe, as a wrong `fault_why`, an extra strobe, or a later read mismatch. Stuck strobes show up in idle cycles that the bench checks directly.

// File: rtl/trmove_pkg.sv
package trmove_pkg;

   typedef enum logic [1:0] {
      WHY_NONE  = 2'd0,
      WHY_PRIV  = 2'd1,
      WHY_MOD   = 2'd2,
      WHY_INDEX = 2'd3
   } fault_why_e;

   typedef struct packed {
      logic       hit;
      logic       to_tr;
      logic [1:0] mode;
      logic [2:0] reg_f;
      logic [2:0] rm_f;
   } trm_dec_t;

   localparam logic [1:0] MODE_REGDIRECT = 2'b11;

endpackage

// File: rtl/trmove_field_split.sv
module trmove_field_split
   import trmove_pkg::*;
#(
   parameter logic [7:0] ESC_BYTE  = 8'h0F,
   parameter logic [7:0] TO_TR     = 8'h26,
   parameter logic [7:0] FROM_TR   = 8'h24
) (
   input  logic [7:0] op_esc,
   input  logic [7:0] op_code,
   input  logic [7:0] modrm,
   output trm_dec_t   dec
);

   logic esc_ok, is_to, is_from;

   always_comb begin
      esc_ok    = (op_esc == ESC_BYTE);
      is_to     = esc_ok && (op_code == TO_TR);
      is_from   = esc_ok && (op_code == FROM_TR);
      dec.hit   = is_to || is_from;
      dec.to_tr = is_to;
      dec.mode  = modrm[7:6];
      dec.reg_f = modrm[5:3];
      dec.rm_f  = modrm[2:0];
   end

endmodule

// File: rtl/trmove_access_chk.sv
module trmove_access_chk
   import trmove_pkg::*;
#(
   parameter int TR_LO   = 3,
   parameter int TR_HI   = 7,
   parameter int CPL_W   = 2
) (
   input  logic             vld,
   input  trm_dec_t         dec,
   input  logic [CPL_W-1:0] cpl,
   input  logic             prot_mode,
   output logic             accept,
   output fault_why_e       why
);

   localparam logic [2:0] LO_IDX = 3'(TR_LO);
   localparam logic [2:0] HI_IDX = 3'(TR_HI);

   logic act, priv_bad, mode_bad, idx_bad;

   always_comb begin
      act      = vld && dec.hit;
      priv_bad = prot_mode && (cpl != '0);
      mode_bad = (dec.mode != MODE_REGDIRECT);
      idx_bad  = (dec.reg_f < LO_IDX) || (dec.reg_f > HI_IDX);
      why      = WHY_NONE;
      accept   = 1'b0;
      if (act) begin
         if (priv_bad)      why = WHY_PRIV;
         else if (mode_bad) why = WHY_MOD;
         else if (idx_bad)  why = WHY_INDEX;
         else               accept = 1'b1;
      end
   end

endmodule

// File: rtl/trmove_regfile.sv
module trmove_regfile #(
   parameter int              DATA_W    = 32,
   parameter int              TR_LO     = 3,
   parameter int              TR_HI     = 7,
   parameter int              CACHE_CMD = 5,
   parameter int              TLB_CMD   = 6,
   parameter logic [DATA_W-1:0] RST_VAL = '0,
   localparam int             NTR       = TR_HI - TR_LO + 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [2:0]        wr_idx,
   input  logic [DATA_W-1:0] wr_data,
   input  logic [2:0]        rd_idx,
   output logic [DATA_W-1:0] rd_data,
   output logic [NTR-1:0]    wr_stb,
   output logic              cache_stb,
   output logic              tlb_stb
);

   localparam logic [2:0] LO_IDX = 3'(TR_LO);

   logic [DATA_W-1:0] val   [NTR];
   logic [NTR-1:0]    cmd_q;
   logic [2:0]        wr_off, rd_off;

   assign wr_off = wr_idx - LO_IDX;
   assign rd_off = rd_idx - LO_IDX;

   for (genvar k = 0; k < NTR; k++) begin : g_tr
      localparam bit IS_CMD = ((k + TR_LO) == CACHE_CMD) || ((k + TR_LO) == TLB_CMD);
      logic sel;
      assign sel = wr_en && (wr_off == 3'(k));

      always_ff @(posedge clk) begin
         if (!rst_n) begin
            val[k]    <= RST_VAL;
            wr_stb[k] <= 1'b0;
         end else begin
            wr_stb[k] <= sel;
            if (sel) val[k] <= wr_data;
         end
      end

      if (IS_CMD) begin : g_cmd
         always_ff @(posedge clk) begin
            if (!rst_n) cmd_q[k] <= 1'b0;
            else        cmd_q[k] <= sel;
         end
      end else begin : g_plain
         assign cmd_q[k] = 1'b0;
      end
   end

   always_comb begin
      rd_data = '0;
      for (int k = 0; k < NTR; k++)
         if (rd_off == 3'(k)) rd_data = val[k];
   end

   assign cache_stb = cmd_q[CACHE_CMD - TR_LO];
   assign tlb_stb   = cmd_q[TLB_CMD - TR_LO];

endmodule

// File: rtl/trmove_dec.sv
module trmove_dec
   import trmove_pkg::*;
#(
   parameter int              DATA_W    = 32,
   parameter int              CPL_W     = 2,
   parameter int              TR_LO     = 3,
   parameter int              TR_HI     = 7,
   parameter int              CACHE_CMD = 5,
   parameter int              TLB_CMD   = 6,
   parameter logic [7:0]      ESC_BYTE  = 8'h0F,
   parameter logic [7:0]      TO_TR     = 8'h26,
   parameter logic [7:0]      FROM_TR   = 8'h24,
   localparam int             NTR       = TR_HI - TR_LO + 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              insn_vld,
   input  logic [7:0]        op_esc,
   input  logic [7:0]        op_code,
   input  logic [7:0]        modrm,
   input  logic [CPL_W-1:0]  cpl,
   input  logic              prot_mode,
   output logic [2:0]        gpr_ridx,
   input  logic [DATA_W-1:0] gpr_rdata,
   output logic              gpr_we,
   output logic [2:0]        gpr_widx,
   output logic [DATA_W-1:0] gpr_wdata,
   output logic [NTR-1:0]    tr_wr_stb,
   output logic              cache_cmd_stb,
   output logic              tlb_cmd_stb,
   output logic              fault_gp,
   output logic              fault_ud,
   output logic [1:0]        fault_why
);

   if (TR_LO < 0 || TR_HI > 7 || TR_LO > TR_HI) begin : g_bad_range
      $error("trmove_dec: test register range must lie within 0..7");
   end
   if (CACHE_CMD < TR_LO || CACHE_CMD > TR_HI || TLB_CMD < TR_LO || TLB_CMD > TR_HI) begin : g_bad_cmd
      $error("trmove_dec: command registers must be implemented");
   end
   if (DATA_W < 1 || CPL_W < 1) begin : g_bad_width
      $error("trmove_dec: widths must be positive");
   end

   trm_dec_t          dec;
   fault_why_e        why;
   logic              accept, do_wr, do_rd;
   logic [DATA_W-1:0] tr_rdata;

   trmove_field_split #(
      .ESC_BYTE (ESC_BYTE),
      .TO_TR    (TO_TR),
      .FROM_TR  (FROM_TR)
   ) split_i (
      .op_esc  (op_esc),
      .op_code (op_code),
      .modrm   (modrm),
      .dec     (dec)
   );

   trmove_access_chk #(
      .TR_LO (TR_LO),
      .TR_HI (TR_HI),
      .CPL_W (CPL_W)
   ) chk_i (
      .vld       (insn_vld),
      .dec       (dec),
      .cpl       (cpl),
      .prot_mode (prot_mode),
      .accept    (accept),
      .why       (why)
   );

   assign do_wr    = accept && dec.to_tr;
   assign do_rd    = accept && !dec.to_tr;
   assign gpr_ridx = dec.rm_f;

   trmove_regfile #(
      .DATA_W    (DATA_W),
      .TR_LO     (TR_LO),
      .TR_HI     (TR_HI),
      .CACHE_CMD (CACHE_CMD),
      .TLB_CMD   (TLB_CMD),
      .RST_VAL   ('0)
   ) rf_i (
      .clk       (clk),
      .rst_n     (rst_n),
      .wr_en     (do_wr),
      .wr_idx    (dec.reg_f),
      .wr_data   (gpr_rdata),
      .rd_idx    (dec.reg_f),
      .rd_data   (tr_rdata),
      .wr_stb    (tr_wr_stb),
      .cache_stb (cache_cmd_stb),
      .tlb_stb   (tlb_cmd_stb)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         gpr_we    <= 1'b0;
         gpr_widx  <= '0;
         gpr_wdata <= '0;
         fault_gp  <= 1'b0;
         fault_ud  <= 1'b0;
         fault_why <= WHY_NONE;
      end else begin
         gpr_we    <= do_rd;
         gpr_widx  <= do_rd ? dec.rm_f : 3'd0;
         gpr_wdata <= do_rd ? tr_rdata : '0;
         fault_gp  <= (why == WHY_PRIV);
         fault_ud  <= (why == WHY_MOD) || (why == WHY_INDEX);
         fault_why <= why;
      end
   end

endmodule

// File: rtl/trmove_dec_chk.sv
module trmove_dec_chk #(
   parameter int NTR   = 5,
   parameter int CPL_W = 2
) (
   input logic             clk,
   input logic             rst_n,
   input logic             insn_vld,
   input logic [7:0]       modrm,
   input logic [CPL_W-1:0] cpl,
   input logic             prot_mode,
   input logic             gpr_we,
   input logic [NTR-1:0]   tr_wr_stb,
   input logic             fault_gp,
   input logic             fault_ud,
   input logic [1:0]       fault_why
);

   // R7
   one_fault_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(fault_gp && fault_ud));

   // R7
   why_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (fault_gp || fault_ud) == (fault_why != 2'd0));

   // R2
   stb_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(tr_wr_stb) && !(gpr_we && (tr_wr_stb != '0)));

   // R9
   needs_vld_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (gpr_we || (tr_wr_stb != '0) || fault_gp || fault_ud) |-> $past(insn_vld));

   // R4
   priv_ok_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (gpr_we || (tr_wr_stb != '0)) |-> (!$past(prot_mode) || ($past(cpl) == '0)));

   // R5
   mode_ok_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (gpr_we || (tr_wr_stb != '0)) |-> ($past(modrm[7:6]) == 2'b11));

   // R6
   fault_no_wr_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (fault_gp || fault_ud) |-> (!gpr_we && (tr_wr_stb == '0)));

endmodule

bind trmove_dec trmove_dec_chk #(.NTR(NTR), .CPL_W(CPL_W)) chk_bind_i (
   .clk       (clk),
   .rst_n     (rst_n),
   .insn_vld  (insn_vld),
   .modrm     (modrm),
   .cpl       (cpl),
   .prot_mode (prot_mode),
   .gpr_we    (gpr_we),
   .tr_wr_stb (tr_wr_stb),
   .fault_gp  (fault_gp),
   .fault_ud  (fault_ud),
   .fault_why (fault_why)
);

// File: tb/trmove_dec_tb_top.sv
module trmove_dec_tb_top;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        insn_vld = 1'b0;
   logic [7:0]  op_esc = '0, op_code = '0, modrm = '0;
   logic [1:0]  cpl = '0;
   logic        prot_mode = 1'b0;
   logic [2:0]  gpr_ridx;
   logic [31:0] gpr_rdata;
   logic        gpr_we;
   logic [2:0]  gpr_widx;
   logic [31:0] gpr_wdata;
   logic [4:0]  tr_wr_stb;
   logic        cache_cmd_stb, tlb_cmd_stb, fault_gp, fault_ud;
   logic [1:0]  fault_why;

   logic [31:0] gpr_m [8];
   logic [31:0] tr_m  [8];
   int checks = 0, errors = 0;
   bit done = 1'b0;

   always #2 clk = ~clk;
   assign gpr_rdata = gpr_m[gpr_ridx];

   trmove_dec dut_i (
      .clk(clk), .rst_n(rst_n), .insn_vld(insn_vld), .op_esc(op_esc),
      .op_code(op_code), .modrm(modrm), .cpl(cpl), .prot_mode(prot_mode),
      .gpr_ridx(gpr_ridx), .gpr_rdata(gpr_rdata), .gpr_we(gpr_we),
      .gpr_widx(gpr_widx), .gpr_wdata(gpr_wdata), .tr_wr_stb(tr_wr_stb),
      .cache_cmd_stb(cache_cmd_stb), .tlb_cmd_stb(tlb_cmd_stb),
      .fault_gp(fault_gp), .fault_ud(fault_ud), .fault_why(fault_why)
   );

   function automatic logic [47:0] pack_out(logic we, logic [2:0] wi, logic [31:0] wd,
         logic [4:0] st, logic cc, logic tc, logic gp, logic ud, logic [1:0] wy);
      return {we, wi, wd, st, cc, tc, gp, ud, wy};
   endfunction

   function automatic logic [47:0] actual();
      return pack_out(gpr_we, gpr_widx, gpr_wdata, tr_wr_stb, cache_cmd_stb,
                      tlb_cmd_stb, fault_gp, fault_ud, fault_why);
   endfunction

   task automatic check(string req, logic [47:0] exp);
      checks++;
      if (actual() !== exp) begin
         errors++;
         $display("FAIL %s actual=%h expected=%h", req, actual(), exp);
      end
   endtask

   // one instruction: drive at negedge, sample at the next negedge
   task automatic run(logic v, logic [7:0] e, logic [7:0] c, logic [7:0] m,
                      logic [1:0] pl, logic pm);
      logic [47:0] exp;
      string req;
      logic hit, to;
      logic [2:0] r, rm;
      exp = '0;
      req = "R9";
      to  = (c == 8'h26);
      hit = v && (e == 8'h0F) && (to || c == 8'h24);
      r   = m[5:3];
      rm  = m[2:0];
      if (hit) begin
         if (pm && pl != 0) begin
            req = "R4"; exp = pack_out(0,0,0,0,0,0,1,0,2'd1);
         end else if (m[7:6] != 2'b11) begin
            req = "R5"; exp = pack_out(0,0,0,0,0,0,0,1,2'd2);
         end else if (r < 3) begin
            req = "R6"; exp = pack_out(0,0,0,0,0,0,0,1,2'd3);
         end else if (to) begin
            req = (r == 5 || r == 6) ? "R8" : "R2";
            exp = pack_out(0,0,0,5'(1 << (r-3)), r == 5, r == 6, 0,0,2'd0);
            tr_m[r] = gpr_m[rm];
         end else begin
            req = "R3"; exp = pack_out(1, rm, tr_m[r], 0,0,0,0,0,2'd0);
         end
      end
      insn_vld = v; op_esc = e; op_code = c; modrm = m; cpl = pl; prot_mode = pm;
      @(negedge clk);
      insn_vld = 1'b0;
      check(req, exp);
   endtask

   task automatic idle_chk(string req);
      @(negedge clk);
      check(req, '0);
   endtask

   initial begin
      #(4 * 150000);
      if (!done) begin
         errors++;
         $display("FAIL watchdog expired");
         $display("  CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin
      void'($urandom(32'h5eed_1234));
      for (int i = 0; i < 8; i++) begin
         gpr_m[i] = $urandom;
         tr_m[i]  = '0;
      end
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      check("R1", '0);
      // R1: all registers read back zero after reset
      for (int r = 3; r < 8; r++) run(1, 8'h0F, 8'h24, {2'b11, 3'(r), 3'(r)}, 0, 1);
      // R2 / R8: write each register, then read back
      for (int r = 3; r < 8; r++) run(1, 8'h0F, 8'h26, {2'b11, 3'(r), 3'(7-r)}, 0, 1);
      idle_chk("R8");
      for (int r = 3; r < 8; r++) run(1, 8'h0F, 8'h24, {2'b11, 3'(r), 3'(r-3)}, 0, 0);
      // R4: real mode allows any level, protected mode does not
      run(1, 8'h0F, 8'h26, {2'b11, 3'd4, 3'd1}, 2'd3, 0);
      run(1, 8'h0F, 8'h26, {2'b11, 3'd4, 3'd2}, 2'd1, 1);
      run(1, 8'h0F, 8'h24, {2'b11, 3'd4, 3'd0}, 2'd0, 1);
      // R7: priority over mod and index faults
      run(1, 8'h0F, 8'h26, {2'b00, 3'd1, 3'd0}, 2'd2, 1);
      run(1, 8'h0F, 8'h26, {2'b01, 3'd0, 3'd0}, 2'd0, 1);
      run(1, 8'h0F, 8'h24, {2'b11, 3'd2, 3'd0}, 2'd0, 0);
      // R5 / R6 leave register 6 intact
      run(1, 8'h0F, 8'h26, {2'b10, 3'd6, 3'd5}, 2'd0, 0);
      run(1, 8'h0F, 8'h24, {2'b11, 3'd6, 3'd3}, 2'd0, 0);
      // R9: other opcodes and no strobe
      run(1, 8'h0F, 8'h22, {2'b11, 3'd3, 3'd3}, 2'd0, 0);
      run(1, 8'h0E, 8'h26, {2'b11, 3'd3, 3'd3}, 2'd0, 0);
      run(0, 8'h0F, 8'h26, {2'b11, 3'd3, 3'd4}, 2'd0, 0);
      run(1, 8'h0F, 8'h24, {2'b11, 3'd3, 3'd4}, 2'd0, 0);
      // random mix
      for (int n = 0; n < 600; n++) begin
         logic [7:0] c, m;
         logic [1:0] pl;
         if (n % 16 == 0) gpr_m[$urandom_range(0, 7)] = $urandom;
         c  = ($urandom_range(0, 9) == 0) ? 8'($urandom) : (($urandom_range(0, 1) != 0) ? 8'h26 : 8'h24);
         m  = 8'($urandom);
         if ($urandom_range(0, 3) != 0) m[7:6] = 2'b11;
         pl = ($urandom_range(0, 3) == 0) ? 2'($urandom) : 2'd0;
         run($urandom_range(0, 7) != 0, 8'h0F, c, m, pl, 1'($urandom));
         if ($urandom_range(0, 9) == 0) idle_chk("R9");
      end
      done = 1'b1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

endmodule